// File: doc/BRIEF.md
# Serial Flash Write and Erase Sequencer

This block carries out whole write-side operations on a serial NOR flash over a single-line SPI link in mode 0. A request gives an operation type, a 24-bit flash address and a length. The block then runs the full command chain on its own. Each operation starts with a write-enable command. The block reads the status register to confirm that the write-enable latch is set. It then sends the program or erase command and polls the status register until the device is no longer busy.

Program data arrives as a byte stream with a valid/ready handshake. The block takes one byte only when that byte is about to go out on the serial line, so it needs no data buffer. For a region erase, the length field holds the region size in bytes and selects the erase opcode. A chip erase ignores both the address and the length. Every operation ends with a one-cycle completion pulse or a one-cycle error pulse.

Top module: `fwseq_top`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `req_ready` is high, and `done`, `err` and `wr_ready` are low.
- R2: A request with op 3, a program length of 0 or above the page size (default 256), or a region-erase length other than 4096, 32768 or 65536 gives a one-cycle `err` pulse. Chip select stays high and no data byte is taken.
- R3: Every accepted operation begins with a transaction that holds only the byte 0x06. Chip select goes high after that byte.
- R4: After each write enable, the block runs a transaction of 0x05 followed by one byte clocked in from the device. If bit WEL_BIT (default 1) of that byte is 0, the block repeats the write enable and the check. After WEN_TRIES failed checks (default 3), it ends with `err` and sends no program or erase command.
- R5: Op 0 (program) sends 0x02, then the address in three bytes with the most significant byte first, then exactly `req_len` bytes from the data stream. Each byte is taken on a cycle where `wr_valid` and `wr_ready` are both high, and `wr_ready` stays high until that happens.
- R6: Op 1 (region erase) sends 0x20 for a length of 4096, 0x52 for 32768 and 0xD8 for 65536, each followed by the three address bytes. Op 2 (chip erase) sends the single byte 0xC7.
- R7: After the program or erase command, the block repeats two-byte transactions of 0x05 and a dummy byte. It stops when bit WIP_BIT (default 0) of the byte read back is 0, and then gives a one-cycle `done` pulse with `req_ready` high.
- R8: Between any two transactions, chip select stays high for at least CS_MIN_SCK serial clock periods (2*SCK_HALF*CS_MIN_SCK system cycles).
- R9: The serial clock idles low while chip select is high. Bytes go out on MOSI with the most significant bit first, MOSI changes only while the clock is low, and MISO is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 2 | 0 program, 1 region erase, 2 chip erase, 3 invalid |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W (17) | Program byte count, or erase region size in bytes |
| wr_valid | input | 1 | Program data byte valid |
| wr_ready | output | 1 | Block waiting for the next program byte |
| wr_data | input | 8 | Program data byte |
| done | output | 1 | One-cycle pulse: operation finished |
| err | output | 1 | One-cycle pulse: request rejected or write enable failed |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Any fault in the sequencing state shows up on the serial bus in the very next transaction. A byte may be wrong, missing or extra, or a transaction may have the wrong length. These errors appear one byte time (about 8*2*SCK_HALF cycles) after the fault. The bench plays the part of the flash, decodes every transaction, and compares it byte for byte with the sequence expected for the request and for the status bytes it returned. A wrong decision on a status bit does not change the current transaction. It shows up one chip-select gap later as an extra or a missing poll or write-enable retry, or as a `done` or `err` pulse that arrives early, late or on the wrong output.

// File: rtl/fwseq_pkg.sv
package fwseq_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_REGION = 2'd1, OP_CHIP = 2'd2, OP_BAD = 2'd3} fw_op_e;
  typedef enum logic [1:0] {PH_WREN, PH_WELCHK, PH_OPER, PH_POLL} fw_phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP} fw_state_e;

  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_RDSR = 8'h05;
  localparam logic [7:0] CMD_PROG = 8'h02;
  localparam logic [7:0] CMD_SEC  = 8'h20;
  localparam logic [7:0] CMD_B32  = 8'h52;
  localparam logic [7:0] CMD_B64  = 8'hD8;
  localparam logic [7:0] CMD_CHIP = 8'hC7;
endpackage

// File: rtl/fwseq_req_check.sv
module fwseq_req_check
  import fwseq_pkg::*;
#(
  parameter int LEN_W      = 17,
  parameter int CNT_W      = 9,
  parameter int PAGE_BYTES = 256,
  parameter int SEC_BYTES  = 4096,
  parameter int B32_BYTES  = 32768,
  parameter int B64_BYTES  = 65536
) (
  input  logic [1:0]       op,
  input  logic [LEN_W-1:0] len,
  output logic             ok,
  output logic [7:0]       opcode,
  output logic [CNT_W-1:0] nbytes
);
  always_comb begin
    ok     = 1'b0;
    opcode = CMD_PROG;
    nbytes = CNT_W'(1);
    case (fw_op_e'(op))
      OP_PROG: begin
        if (len != '0 && len <= LEN_W'(PAGE_BYTES)) begin
          ok     = 1'b1;
          nbytes = CNT_W'(len) + CNT_W'(4);
        end
      end
      OP_REGION: begin
        nbytes = CNT_W'(4);
        if (len == LEN_W'(SEC_BYTES)) begin
          ok = 1'b1; opcode = CMD_SEC;
        end else if (len == LEN_W'(B32_BYTES)) begin
          ok = 1'b1; opcode = CMD_B32;
        end else if (len == LEN_W'(B64_BYTES)) begin
          ok = 1'b1; opcode = CMD_B64;
        end
      end
      OP_CHIP: begin
        ok     = 1'b1;
        opcode = CMD_CHIP;
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/fwseq_spi_eng.sv
module fwseq_spi_eng #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int HC_W = $clog2(SCK_HALF + 1);

  logic            act;
  logic [HC_W-1:0] hc;
  logic [2:0]      bitn;
  logic [7:0]      sh;
  logic [7:0]      rsh;

  assign rx = rsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      hc   <= '0;
      bitn <= '0;
      sh   <= '0;
      rsh  <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !act) begin
        act  <= 1'b1;
        sh   <= tx;
        mosi <= tx[7];
        hc   <= '0;
        bitn <= '0;
        sclk <= 1'b0;
      end else if (act) begin
        if (hc == HC_W'(SCK_HALF - 1)) begin
          hc <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rsh  <= {rsh[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              act  <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
              mosi <= sh[6];
            end
          end
        end else begin
          hc <= hc + HC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fwseq_ctrl.sv
module fwseq_ctrl
  import fwseq_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int GAP_CYC   = 4,
  parameter int WEL_BIT   = 1,
  parameter int WIP_BIT   = 0,
  parameter int WEN_TRIES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [23:0]      req_addr,
  input  logic             req_ok,
  input  logic [7:0]       req_opcode,
  input  logic [CNT_W-1:0] req_nbytes,
  output logic             req_ready,
  output logic             done,
  output logic             err,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             eng_start,
  output logic [7:0]       eng_tx,
  input  logic             eng_done,
  input  logic [7:0]       eng_rx,
  output logic             cs_n
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int TRY_W = $clog2(WEN_TRIES + 1);

  fw_state_e        st;
  fw_phase_e        ph;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] nb_q;
  logic [CNT_W-1:0] tr_len;
  logic [7:0]       opc_q;
  logic [23:0]      addr_q;
  logic [7:0]       stat_q;
  logic [TRY_W-1:0] tries;
  logic [GAP_W-1:0] gcnt;

  always_comb begin
    case (ph)
      PH_WREN: tr_len = CNT_W'(1);
      PH_OPER: tr_len = nb_q;
      default: tr_len = CNT_W'(2);
    endcase
  end

  always_comb begin
    case (ph)
      PH_WREN: eng_tx = CMD_WREN;
      PH_OPER: begin
        if (idx == CNT_W'(0))      eng_tx = opc_q;
        else if (idx == CNT_W'(1)) eng_tx = addr_q[23:16];
        else if (idx == CNT_W'(2)) eng_tx = addr_q[15:8];
        else if (idx == CNT_W'(3)) eng_tx = addr_q[7:0];
        else                       eng_tx = wr_data;
      end
      default: eng_tx = (idx == CNT_W'(0)) ? CMD_RDSR : 8'h00;
    endcase
  end

  assign eng_start = (st == ST_LOAD) && (!wr_ready || wr_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= PH_WREN;
      idx       <= '0;
      nb_q      <= '0;
      opc_q     <= '0;
      addr_q    <= '0;
      stat_q    <= '0;
      tries     <= '0;
      gcnt      <= '0;
      req_ready <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
      wr_ready  <= 1'b0;
      cs_n      <= 1'b1;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_ok) begin
              opc_q     <= req_opcode;
              addr_q    <= req_addr;
              nb_q      <= req_nbytes;
              tries     <= '0;
              ph        <= PH_WREN;
              idx       <= '0;
              st        <= ST_LOAD;
              cs_n      <= 1'b0;
              req_ready <= 1'b0;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (eng_start) begin
            st       <= ST_SHIFT;
            wr_ready <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (eng_done) begin
            stat_q <= eng_rx;
            if (idx == tr_len - CNT_W'(1)) begin
              st   <= ST_GAP;
              cs_n <= 1'b1;
              gcnt <= '0;
            end else begin
              idx      <= idx + CNT_W'(1);
              st       <= ST_LOAD;
              wr_ready <= (ph == PH_OPER) && (idx + CNT_W'(1) >= CNT_W'(4));
            end
          end
        end
        default: begin
          if (gcnt == GAP_W'(GAP_CYC - 1)) begin
            st   <= ST_LOAD;
            idx  <= '0;
            cs_n <= 1'b0;
            case (ph)
              PH_WREN: ph <= PH_WELCHK;
              PH_WELCHK: begin
                if (stat_q[WEL_BIT]) begin
                  ph <= PH_OPER;
                end else if (tries == TRY_W'(WEN_TRIES - 1)) begin
                  st        <= ST_IDLE;
                  cs_n      <= 1'b1;
                  err       <= 1'b1;
                  req_ready <= 1'b1;
                end else begin
                  tries <= tries + TRY_W'(1);
                  ph    <= PH_WREN;
                end
              end
              PH_OPER: ph <= PH_POLL;
              default: begin
                if (!stat_q[WIP_BIT]) begin
                  st        <= ST_IDLE;
                  cs_n      <= 1'b1;
                  done      <= 1'b1;
                  req_ready <= 1'b1;
                end
              end
            endcase
          end else begin
            gcnt <= gcnt + GAP_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fwseq_top.sv
module fwseq_top #(
  parameter int LEN_W      = 17,
  parameter int PAGE_BYTES = 256,
  parameter int SEC_BYTES  = 4096,
  parameter int B32_BYTES  = 32768,
  parameter int B64_BYTES  = 65536,
  parameter int SCK_HALF   = 2,
  parameter int CS_MIN_SCK = 1,
  parameter int WEL_BIT    = 1,
  parameter int WIP_BIT    = 0,
  parameter int WEN_TRIES  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             done,
  output logic             err,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int CNT_W   = $clog2(PAGE_BYTES + 5);
  localparam int GAP_CYC = 2 * SCK_HALF * ((CS_MIN_SCK < 1) ? 1 : CS_MIN_SCK);

  logic             chk_ok;
  logic [7:0]       chk_opcode;
  logic [CNT_W-1:0] chk_nbytes;
  logic             eng_start;
  logic [7:0]       eng_tx;
  logic             eng_done;
  logic [7:0]       eng_rx;

  fwseq_req_check #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES),
    .SEC_BYTES(SEC_BYTES), .B32_BYTES(B32_BYTES), .B64_BYTES(B64_BYTES)
  ) u_check (
    .op(req_op), .len(req_len), .ok(chk_ok), .opcode(chk_opcode), .nbytes(chk_nbytes)
  );

  fwseq_ctrl #(
    .CNT_W(CNT_W), .GAP_CYC(GAP_CYC), .WEL_BIT(WEL_BIT),
    .WIP_BIT(WIP_BIT), .WEN_TRIES(WEN_TRIES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ok(chk_ok), .req_opcode(chk_opcode), .req_nbytes(chk_nbytes),
    .req_ready(req_ready), .done(done), .err(err),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .eng_start(eng_start), .eng_tx(eng_tx), .eng_done(eng_done), .eng_rx(eng_rx),
    .cs_n(spi_cs_n)
  );

  fwseq_spi_eng #(.SCK_HALF(SCK_HALF)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .tx(eng_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(eng_done), .rx(eng_rx)
  );
endmodule

// File: rtl/fwseq_sva.sv
module fwseq_sva #(
  parameter int GAP_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic req_ready,
  input logic wr_ready,
  input logic wr_valid,
  input logic done,
  input logic err
);
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)           hi_cnt <= GAP_CYC;
    else if (spi_cs_n) hi_cnt <= (hi_cnt < GAP_CYC) ? hi_cnt + 1 : hi_cnt;
    else               hi_cnt <= 0;
  end

  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> hi_cnt >= GAP_CYC);

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  assert_done_ready_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && !wr_valid) |=> wr_ready);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!wr_ready && spi_cs_n));
endmodule

bind fwseq_top fwseq_sva #(.GAP_CYC(GAP_CYC)) u_sva (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .req_ready(req_ready), .wr_ready(wr_ready), .wr_valid(wr_valid),
  .done(done), .err(err)
);

// File: tb/fwseq_top_tb.sv
module fwseq_top_tb;
  localparam int PAGE = 256, HALF = 2, CSMIN = 1, WEL = 1, WIP = 0, TRIES = 3;
  localparam int GAP = 2 * HALF * CSMIN;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, wr_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [16:0] req_len = '0;
  logic [7:0]  wr_data = '0;
  logic        req_ready, wr_ready, done, err, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #5 clk = ~clk;

  fwseq_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .done(done), .err(err), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // flash model / bus monitor
  logic [7:0] mlog [0:1023];
  int         tst [0:255];
  int         tlen [0:255];
  int nb = 0, nt = 0, bc = 0, cur_len = 0, hicnt = 1000, n_wc = 0, n_pl = 0, n_hs = 0;
  int cfg_wf = 0, cfg_busy = 0, base_wc = 0, base_pl = 0;
  logic [7:0] sh = '0, stat = '0, tfirst = '0, prev_first = '0;
  logic pcs = 1'b1, psclk = 1'b0, in_tr = 1'b0;

  assign spi_miso = (in_tr && cur_len == 1 && tfirst == 8'h05) ? stat[3'(7 - bc)] : 1'b0;

  always @(posedge clk) if (!rst && wr_valid && wr_ready) n_hs++;

  always @(negedge clk) begin
    if (rst) begin
      pcs = 1'b1; psclk = 1'b0; in_tr = 1'b0; hicnt = 1000;
    end else begin
      if (pcs && !spi_cs_n) begin
        chk(hicnt >= GAP, "R8 cs high gap", hicnt, GAP);
        in_tr = 1'b1; bc = 0; cur_len = 0; tst[nt & 255] = nb;
      end
      if (!spi_cs_n && !psclk && spi_sclk) begin
        sh = {sh[6:0], spi_mosi};
        bc++;
        if (bc == 8) begin
          bc = 0;
          mlog[nb & 1023] = sh;
          nb++;
          if (cur_len == 0) begin
            tfirst = sh;
            if (sh == 8'h05) begin
              stat = 8'((nb * 37) & 8'hFF);
              if (prev_first == 8'h06) begin
                if ((n_wc - base_wc) < cfg_wf) stat[WEL] = 1'b0; else stat[WEL] = 1'b1;
                n_wc++;
              end else begin
                if ((n_pl - base_pl) < cfg_busy) stat[WIP] = 1'b1; else stat[WIP] = 1'b0;
                n_pl++;
              end
            end
          end
          cur_len++;
        end
      end
      if (!pcs && spi_cs_n && in_tr) begin
        tlen[nt & 255] = cur_len; prev_first = tfirst; nt++; in_tr = 1'b0;
      end
      hicnt = spi_cs_n ? hicnt + 1 : 0;
      pcs = spi_cs_n; psclk = spi_sclk;
    end
  end

  // expected sequence
  logic [7:0] eb [0:1023];
  int    est [0:63];
  int    etl [0:63];
  string elab [0:63];
  int    ent, enb;
  logic [7:0] dat [0:255];

  task automatic ex_open(input string l);
    est[ent] = enb; etl[ent] = 0; elab[ent] = l;
  endtask
  task automatic ex_byte(input logic [7:0] b);
    eb[enb] = b; enb++; etl[ent]++;
  endtask
  task automatic ex_close();
    ent++;
  endtask

  function automatic bit exp_valid(input int op, input int len);
    if (op == 0) return (len >= 1 && len <= PAGE);
    if (op == 1) return (len == 4096 || len == 32768 || len == 65536);
    return (op == 2);
  endfunction

  function automatic logic [7:0] exp_opc(input int op, input int len);
    if (op == 0) return 8'h02;
    if (op == 2) return 8'hC7;
    if (len == 4096) return 8'h20;
    if (len == 32768) return 8'h52;
    return 8'hD8;
  endfunction

  task automatic run_op(input int op, input int addr, input int len, input int wf, input int busy);
    int bnt, bhs, ntry, ndat, tmo, t, tl, mism, ma, me;
    bit vld, exdone, exerr, gd, ge;
    vld = exp_valid(op, len);
    for (int j = 0; j < 256; j++) dat[j] = 8'($urandom_range(0, 255));
    ent = 0; enb = 0;
    exdone = 1'b0; exerr = 1'b0; ndat = 0;
    if (!vld) exerr = 1'b1;
    else begin
      ntry = (wf >= TRIES) ? TRIES : wf + 1;
      for (int i = 0; i < ntry; i++) begin
        ex_open("R3 write enable"); ex_byte(8'h06); ex_close();
        ex_open("R4 latch check"); ex_byte(8'h05); ex_byte(8'h00); ex_close();
      end
      if (wf >= TRIES) exerr = 1'b1;
      else begin
        ex_open(op == 0 ? "R5 program cmd" : "R6 erase cmd");
        ex_byte(exp_opc(op, len));
        if (op != 2) begin
          ex_byte(addr[23:16]); ex_byte(addr[15:8]); ex_byte(addr[7:0]);
        end
        if (op == 0) begin
          for (int j = 0; j < len; j++) ex_byte(dat[j]);
          ndat = len;
        end
        ex_close();
        for (int i = 0; i <= busy; i++) begin
          ex_open("R7 busy poll"); ex_byte(8'h05); ex_byte(8'h00); ex_close();
        end
        exdone = 1'b1;
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_wf = wf; cfg_busy = busy; base_wc = n_wc; base_pl = n_pl;
    bnt = nt; bhs = n_hs;
    gd = 1'b0; ge = 1'b0;
    fork
      begin
        req_valid = 1'b1; req_op = 2'(op); req_addr = 24'(addr); req_len = 17'(len);
        @(negedge clk);
        req_valid = 1'b0;
        tmo = 0;
        while (!(done || err) && tmo < 60000) begin
          @(negedge clk); tmo++;
        end
        gd = done; ge = err;
        chk(tmo < 60000, "R7 operation finishes", tmo, 0);
      end
      begin
        for (int j = 0; j < ndat; j++) begin
          repeat ($urandom_range(0, 2)) @(negedge clk);
          wr_valid = 1'b1; wr_data = dat[j];
          while (!wr_ready) @(negedge clk);
          @(negedge clk);
          wr_valid = 1'b0;
        end
      end
    join
    repeat (3) @(negedge clk);
    chk(gd == exdone, vld ? "R7 done pulse" : "R2 no done", int'(gd), int'(exdone));
    chk(ge == exerr, vld ? "R4 err pulse" : "R2 reject err", int'(ge), int'(exerr));
    chk(nt - bnt == ent, vld ? "R3 transaction count" : "R2 no transaction", nt - bnt, ent);
    chk(n_hs - bhs == ndat, vld ? "R5 bytes taken" : "R2 no bytes taken", n_hs - bhs, ndat);
    for (t = 0; t < ent && t < nt - bnt; t++) begin
      tl = tlen[(bnt + t) & 255];
      chk(tl == etl[t], elab[t], tl, etl[t]);
      mism = 0; ma = 0; me = 0;
      for (int k = 0; k < etl[t] && k < tl; k++) begin
        if (mism == 0 && mlog[(tst[(bnt + t) & 255] + k) & 1023] != eb[est[t] + k]) begin
          mism = 1; ma = mlog[(tst[(bnt + t) & 255] + k) & 1023]; me = eb[est[t] + k];
        end
      end
      chk(mism == 0, {elab[t], " R9 byte"}, ma, me);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int op, len;
    void'($urandom(32'd7341));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R1 sclk", int'(spi_sclk), 0);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(!done && !err && !wr_ready, "R1 flags", int'({done, err, wr_ready}), 0);
    // directed corners
    run_op(0, 24'h123456, 4, 0, 0);        // R5
    run_op(0, 24'hABCD00, 256, 0, 2);      // R5 full page
    run_op(0, 24'h000010, 0, 0, 0);        // R2 zero length
    run_op(0, 24'h000010, 257, 0, 0);      // R2 over a page
    run_op(1, 24'h001000, 4096, 0, 1);     // R6 sector
    run_op(1, 24'h018000, 32768, 0, 0);    // R6 32K
    run_op(1, 24'h7F0000, 65536, 1, 0);    // R6 64K, R4 one retry
    run_op(1, 24'h001000, 5000, 0, 0);     // R2 unsupported size
    run_op(3, 24'h000000, 4, 0, 0);        // R2 invalid op
    run_op(2, 24'hFFFFFF, 0, 0, 3);        // R6 chip erase, R7 polls
    run_op(0, 24'h00FF01, 3, 2, 1);        // R4 last retry passes
    run_op(1, 24'h002000, 4096, 3, 0);     // R4 retries exhausted
    // random mix
    for (int n = 0; n < 25; n++) begin
      op = $urandom_range(0, 3);
      case (op)
        0: len = $urandom_range(0, 20);
        1: case ($urandom_range(0, 3))
             0: len = 4096; 1: len = 32768; 2: len = 65536; default: len = $urandom_range(1, 70000);
           endcase
        default: len = $urandom_range(0, 10);
      endcase
      run_op(op, $urandom_range(0, 24'hFFFFFF), len, $urandom_range(0, 3), $urandom_range(0, 4));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule